// File: doc/BRIEF.md
# Checked Serial Register-Write Receiver

This block is the receive front end of a register-mapped peripheral that sits on a shared serial bus. The serial clock, active-low select and data line are brought into the system clock domain and oversampled. While select is held low, the block samples one data bit on each sampling edge of the serial clock. Clock polarity and phase inputs pick that edge. When select is released, the collected frame is judged, and at most one single-cycle result pulse follows.

A frame carries a 24-bit payload, most significant bit first. With integrity checking on, an 8-bit CRC follows the payload. The payload holds, from the top: one slip bit, a 2-bit device address, a 5-bit register index and a 16-bit value. A frame is turned into a write strobe only when four tests hold: it has the right length, its slip bit is the inverse of the bit below it, its CRC remainder is zero, and its device address equals the two strap pins. A slip failure and a CRC failure each raise their own error pulse. A wrong length or a foreign address drops the frame without any pulse.

Top module: `spi_frame_checker`

## Requirements
- R1: Bits are sampled on the rising serial-clock edge when `cpol` equals `cpha` (modes 0 and 3), and on the falling edge otherwise (modes 1 and 2). The clock idles at the level of `cpol`.
- R2: An accepted payload is laid out, from bit 23 down, as slip bit, device address [22:21], register index [20:16] and value [15:0]. On acceptance, `wr_reg` and `wr_data` carry the index and value in the same cycle as `wr_strobe`.
- R3: With `crc_en`=1, the 8 bits after the payload must equal the CRC of the 24 payload bits, computed MSB first with polynomial x^8+x^2+x+1 (0x07), initial value 0x00 and no final inversion. On a mismatch, `crc_err` pulses and no write happens.
- R4: Payload bit 23 must be the inverse of bit 22. If it is not, `slip_err` pulses and the frame is dropped. This check takes precedence over the CRC, so a frame failing both raises only `slip_err`.
- R5: A frame whose device address differs from `dev_addr_pins` is dropped with no pulse. Each of the four pin values selects only frames carrying that address.
- R6: A frame whose count of sampling edges differs from the expected length when select rises (32 with CRC, 24 without) is dropped with no pulse.
- R7: With `crc_en`=0, a 24-bit frame is judged by its slip bit and address only, with no CRC.
- R8: `wr_strobe`, `slip_err` and `crc_err` are each high for one cycle per frame. At most one of them is high at a time, and they only rise after select has been released.
- R9: After reset, all outputs are 0. `wr_reg` and `wr_data` hold the last accepted values until the next write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the bus controller |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the block |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase; with `cpol` selects the sampling edge |
| crc_en | input | 1 | 1: 32-bit frames with CRC; 0: 24-bit frames without |
| dev_addr_pins | input | 2 | Strap value the frame's device address must match |
| wr_strobe | output | 1 | One-cycle register write request |
| wr_reg | output | 5 | Register index of the last accepted write |
| wr_data | output | 16 | Value of the last accepted write |
| slip_err | output | 1 | One-cycle pulse on a slip-bit failure |
| crc_err | output | 1 | One-cycle pulse on a CRC failure |

## Verification
Valid frames are sent in all four clock modes with different values. A wrong sampling edge would shift every bit and corrupt both the fields and the CRC, so these frames show that each mode picks its edge correctly. Single-bit corruptions of the check byte, of the slip bit, and of both together show that a CRC failure, a slip failure and their precedence are kept apart. Frames of 31 and 33 bits, frames addressed to each of the four devices, and 24-bit frames with the CRC switched off show the silent discards and the second frame length. After every rejected frame, the write outputs are compared against the last accepted write.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

    // Outcome of judging one completed frame
    typedef enum logic [1:0] {
        VERDICT_DROP  = 2'd0,
        VERDICT_WRITE = 2'd1,
        VERDICT_SLIP  = 2'd2,
        VERDICT_CRC   = 2'd3
    } verdict_e;

endpackage

// File: rtl/spi_fc_sync.sv
// Brings the serial pins into the clk domain and finds sampling edges
// and select transitions.
module spi_fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    input  logic sample_on_rise,
    output logic sample_pulse,
    output logic sample_bit,
    output logic frame_start,
    output logic frame_end
);
    typedef struct packed {
        logic [STAGES-1:0] sclk_p;
        logic [STAGES-1:0] cs_p;
        logic [STAGES-1:0] mosi_p;
        logic              sclk_last;
        logic              cs_last;
    } sync_t;

    sync_t s_d, s_q;

    logic sclk_s, cs_s, rise, fall;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_p    = {s_q.sclk_p[STAGES-2:0], sclk_in};
        s_d.cs_p      = {s_q.cs_p[STAGES-2:0], cs_n_in};
        s_d.mosi_p    = {s_q.mosi_p[STAGES-2:0], mosi_in};
        s_d.sclk_last = s_q.sclk_p[STAGES-1];
        s_d.cs_last   = s_q.cs_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sclk_p    <= '0;
            s_q.cs_p      <= '1;
            s_q.mosi_p    <= '0;
            s_q.sclk_last <= 1'b0;
            s_q.cs_last   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        sclk_s       = s_q.sclk_p[STAGES-1];
        cs_s         = s_q.cs_p[STAGES-1];
        rise         = sclk_s & ~s_q.sclk_last;
        fall         = ~sclk_s & s_q.sclk_last;
        sample_pulse = ~cs_s & (sample_on_rise ? rise : fall);
        sample_bit   = s_q.mosi_p[STAGES-1];
        frame_start  = s_q.cs_last & ~cs_s;
        frame_end    = ~s_q.cs_last & cs_s;
    end

endmodule

// File: rtl/spi_fc_shift.sv
// Collects frame bits, counts sampling edges and runs the serial CRC.
module spi_fc_shift #(
    parameter int                 FRAME_W  = 32,
    parameter int                 CRC_W    = 8,
    parameter logic [CRC_W-1:0]   CRC_POLY = 8'h07,
    parameter int                 CNT_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               sample_pulse,
    input  logic               sample_bit,
    output logic [FRAME_W-1:0] shift_q,
    output logic [CNT_W-1:0]   count_q,
    output logic [CRC_W-1:0]   rem_q
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic [CRC_W-1:0]   rem;
    } shift_t;

    shift_t f_d, f_q;
    logic   feedback;

    always_comb begin
        f_d      = f_q;
        feedback = f_q.rem[CRC_W-1] ^ sample_bit;
        if (frame_start) begin
            f_d.sr  = '0;
            f_d.cnt = '0;
            f_d.rem = '0;
        end else if (sample_pulse) begin
            f_d.sr  = {f_q.sr[FRAME_W-2:0], sample_bit};
            f_d.cnt = (f_q.cnt == '1) ? f_q.cnt : f_q.cnt + 1'b1;
            f_d.rem = {f_q.rem[CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign shift_q = f_q.sr;
    assign count_q = f_q.cnt;
    assign rem_q   = f_q.rem;

endmodule

// File: rtl/spi_fc_judge.sv
// Decides what a finished frame becomes and registers the results.
module spi_fc_judge
    import spi_fc_pkg::*;
#(
    parameter int DEV_W  = 2,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    parameter int CRC_W  = 8,
    parameter int CNT_W  = 7,
    localparam int PAYLOAD_W = 1 + DEV_W + REG_W + DATA_W,
    localparam int FRAME_W   = PAYLOAD_W + CRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end,
    input  logic               crc_en,
    input  logic [DEV_W-1:0]   dev_pins,
    input  logic [FRAME_W-1:0] shift_q,
    input  logic [CNT_W-1:0]   count_q,
    input  logic [CRC_W-1:0]   rem_q,
    output logic               wr_strobe,
    output logic [REG_W-1:0]   wr_reg,
    output logic [DATA_W-1:0]  wr_data,
    output logic               slip_err,
    output logic               crc_err
);
    typedef struct packed {
        logic              strobe;
        logic [REG_W-1:0]  reg_a;
        logic [DATA_W-1:0] data;
        logic              slip;
        logic              crc;
    } out_t;

    out_t o_d, o_q;

    logic [PAYLOAD_W-1:0] payload;
    logic [CNT_W-1:0]     want_len;
    logic                 len_ok, slip_ok, crc_ok, addr_ok;
    verdict_e             verdict;

    always_comb begin
        payload  = crc_en ? shift_q[FRAME_W-1:CRC_W] : shift_q[PAYLOAD_W-1:0];
        want_len = crc_en ? CNT_W'(FRAME_W) : CNT_W'(PAYLOAD_W);
        len_ok   = (count_q == want_len);
        slip_ok  = payload[PAYLOAD_W-1] != payload[PAYLOAD_W-2];
        crc_ok   = !crc_en || (rem_q == '0);
        addr_ok  = payload[PAYLOAD_W-2 -: DEV_W] == dev_pins;

        if (!len_ok)       verdict = VERDICT_DROP;
        else if (!slip_ok) verdict = VERDICT_SLIP;
        else if (!crc_ok)  verdict = VERDICT_CRC;
        else if (!addr_ok) verdict = VERDICT_DROP;
        else               verdict = VERDICT_WRITE;

        o_d        = o_q;
        o_d.strobe = 1'b0;
        o_d.slip   = 1'b0;
        o_d.crc    = 1'b0;
        if (frame_end) begin
            unique case (verdict)
                VERDICT_WRITE: begin
                    o_d.strobe = 1'b1;
                    o_d.reg_a  = payload[DATA_W +: REG_W];
                    o_d.data   = payload[DATA_W-1:0];
                end
                VERDICT_SLIP:  o_d.slip = 1'b1;
                VERDICT_CRC:   o_d.crc  = 1'b1;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign wr_strobe = o_q.strobe;
    assign wr_reg    = o_q.reg_a;
    assign wr_data   = o_q.data;
    assign slip_err  = o_q.slip;
    assign crc_err   = o_q.crc;

endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker #(
    parameter int               DEV_W       = 2,
    parameter int               REG_W       = 5,
    parameter int               DATA_W      = 16,
    parameter int               CRC_W       = 8,
    parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              crc_en,
    input  logic [DEV_W-1:0]  dev_addr_pins,
    output logic              wr_strobe,
    output logic [REG_W-1:0]  wr_reg,
    output logic [DATA_W-1:0] wr_data,
    output logic              slip_err,
    output logic              crc_err
);
    localparam int PAYLOAD_W = 1 + DEV_W + REG_W + DATA_W;
    localparam int FRAME_W   = PAYLOAD_W + CRC_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1) + 1;

    logic               sample_pulse, sample_bit, frame_start, frame_end;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   count_q;
    logic [CRC_W-1:0]   rem_q;

    spi_fc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_in        (spi_sclk),
        .cs_n_in        (spi_cs_n),
        .mosi_in        (spi_mosi),
        .sample_on_rise (cpol == cpha),
        .sample_pulse   (sample_pulse),
        .sample_bit     (sample_bit),
        .frame_start    (frame_start),
        .frame_end      (frame_end)
    );

    spi_fc_shift #(
        .FRAME_W  (FRAME_W),
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY),
        .CNT_W    (CNT_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .sample_pulse (sample_pulse),
        .sample_bit   (sample_bit),
        .shift_q      (shift_q),
        .count_q      (count_q),
        .rem_q        (rem_q)
    );

    spi_fc_judge #(
        .DEV_W  (DEV_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .CNT_W  (CNT_W)
    ) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .crc_en    (crc_en),
        .dev_pins  (dev_addr_pins),
        .shift_q   (shift_q),
        .count_q   (count_q),
        .rem_q     (rem_q),
        .wr_strobe (wr_strobe),
        .wr_reg    (wr_reg),
        .wr_data   (wr_data),
        .slip_err  (slip_err),
        .crc_err   (crc_err)
    );

endmodule

// File: rtl/spi_fc_checker.sv
module spi_fc_checker #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              wr_strobe,
    input logic [REG_W-1:0]  wr_reg,
    input logic [DATA_W-1:0] wr_data,
    input logic              slip_err,
    input logic              crc_err
);
    p_strobe_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    p_slip_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slip_err |=> !slip_err);

    p_crc_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err);

    p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, slip_err, crc_err}));

    p_pulse_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe || slip_err || crc_err) |-> spi_cs_n);

    p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |-> ($stable(wr_reg) && $stable(wr_data)));

endmodule

bind spi_frame_checker spi_fc_checker #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .wr_strobe (wr_strobe),
    .wr_reg    (wr_reg),
    .wr_data   (wr_data),
    .slip_err  (slip_err),
    .crc_err   (crc_err)
);

// File: tb/spi_frame_checker_bench.sv
`timescale 1ns/1ps
module spi_frame_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        cpol = 1'b0, cpha = 1'b0, crc_en = 1'b1;
    logic [1:0]  dev_addr_pins = 2'b10;
    logic        wr_strobe, slip_err, crc_err;
    logic [4:0]  wr_reg;
    logic [15:0] wr_data;

    int total = 0, bad = 0;
    int n_wr = 0, n_wr_hi = 0, n_slip = 0, n_crc = 0;
    logic wr_prev = 1'b0;
    logic [4:0]  exp_reg = '0;
    logic [15:0] exp_data = '0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_frame_checker u_spi_frame_checker (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .cpol(cpol), .cpha(cpha), .crc_en(crc_en),
        .dev_addr_pins(dev_addr_pins), .wr_strobe(wr_strobe), .wr_reg(wr_reg),
        .wr_data(wr_data), .slip_err(slip_err), .crc_err(crc_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe) n_wr_hi++;
            if (wr_strobe && !wr_prev) n_wr++;
            if (slip_err) n_slip++;
            if (crc_err) n_crc++;
        end
        wr_prev <= wr_strobe;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc8(input logic [23:0] p);
        logic [7:0] c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            logic fb = c[7] ^ p[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [23:0] payload(input logic [1:0] a, input logic [4:0] r,
                                            input logic [15:0] d, input bit slip_ok);
        return {slip_ok ? ~a[1] : a[1], a, r, d};
    endfunction

    function automatic logic [39:0] with_crc(input logic [23:0] p);
        return {8'h00, p, crc8(p)};
    endfunction

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [39:0] bits, input int n, input logic cp, input logic ph);
        @(negedge clk);
        cpol = cp; cpha = ph; spi_sclk = cp;
        half();
        spi_cs_n = 1'b0;
        half();
        for (int i = n - 1; i >= 0; i--) begin
            if (!ph) begin
                spi_mosi = bits[i]; half();
                spi_sclk = ~spi_sclk; half();
                spi_sclk = ~spi_sclk;
            end else begin
                spi_sclk = ~spi_sclk; spi_mosi = bits[i]; half();
                spi_sclk = ~spi_sclk; half();
            end
        end
        half();
        spi_cs_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic frame(input string req, input logic [39:0] bits, input int n,
                         input logic cp, input logic ph, input int e_wr,
                         input int e_slip, input int e_crc,
                         input logic [4:0] r, input logic [15:0] d);
        int w0 = n_wr, s0 = n_slip, c0 = n_crc;
        send(bits, n, cp, ph);
        if (e_wr != 0) begin exp_reg = r; exp_data = d; end
        chk(n_wr - w0 == e_wr, req, n_wr - w0, e_wr);
        chk(n_slip - s0 == e_slip, req, n_slip - s0, e_slip);
        chk(n_crc - c0 == e_crc, req, n_crc - c0, e_crc);
        chk(wr_reg == exp_reg && wr_data == exp_data, req,
            {wr_reg, wr_data}, {exp_reg, exp_data});
    endtask

    task automatic t_reset();
        chk(!wr_strobe && !slip_err && !crc_err, "R9 reset pulses",
            {wr_strobe, slip_err, crc_err}, 0);
        chk(wr_reg == 0 && wr_data == 0, "R9 reset fields", {wr_reg, wr_data}, 0);
    endtask

    task automatic t_modes();
        frame("R1 R2 mode0", with_crc(payload(2'b10, 5'h01, 16'hAAAA, 1)), 32, 0, 0, 1, 0, 0, 5'h01, 16'hAAAA);
        frame("R1 mode1", with_crc(payload(2'b10, 5'h06, 16'h0C40, 1)), 32, 0, 1, 1, 0, 0, 5'h06, 16'h0C40);
        frame("R1 mode2", with_crc(payload(2'b10, 5'h14, 16'h2000, 1)), 32, 1, 0, 1, 0, 0, 5'h14, 16'h2000);
        frame("R1 mode3", with_crc(payload(2'b10, 5'h1F, 16'h5335, 1)), 32, 1, 1, 1, 0, 0, 5'h1F, 16'h5335);
    endtask

    task automatic t_crc();
        logic [39:0] f = with_crc(payload(2'b10, 5'h08, 16'h15FA, 1));
        frame("R3 bad crc lsb", f ^ 40'h1, 32, 0, 0, 0, 0, 1, 0, 0);
        frame("R3 bad data bit", f ^ 40'h100, 32, 1, 1, 0, 0, 1, 0, 0);
        frame("R3 good crc", f, 32, 0, 0, 1, 0, 0, 5'h08, 16'h15FA);
    endtask

    task automatic t_slip();
        logic [23:0] p = payload(2'b10, 5'h09, 16'h0204, 0);
        frame("R4 slip, good crc", with_crc(p), 32, 0, 0, 0, 1, 0, 0, 0);
        frame("R4 slip precedence", with_crc(p) ^ 40'h4, 32, 0, 1, 0, 1, 0, 0, 0);
    endtask

    task automatic t_addr();
        for (int a = 0; a < 4; a++) begin
            logic [1:0] aa = 2'(a);
            frame("R5 address", with_crc(payload(aa, 5'h0C, 16'h0100 + 16'(a), 1)), 32, 0, 0,
                  (aa == 2'b10) ? 1 : 0, 0, 0, 5'h0C, 16'h0100 + 16'(a));
        end
        dev_addr_pins = 2'b01;
        frame("R5 pins changed", with_crc(payload(2'b01, 5'h02, 16'h7E7E, 1)), 32, 0, 0, 1, 0, 0, 5'h02, 16'h7E7E);
        frame("R5 old address", with_crc(payload(2'b10, 5'h03, 16'h1111, 1)), 32, 0, 0, 0, 0, 0, 0, 0);
        dev_addr_pins = 2'b10;
    endtask

    task automatic t_length();
        logic [39:0] f = with_crc(payload(2'b10, 5'h04, 16'hBEEF, 1));
        frame("R6 short 31", f >> 1, 31, 0, 0, 0, 0, 0, 0, 0);
        frame("R6 long 33", {f[38:0], 1'b0}, 33, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_nocrc();
        crc_en = 1'b0;
        frame("R7 24-bit write", {16'h0, payload(2'b10, 5'h07, 16'h1DAC, 1)}, 24, 0, 0, 1, 0, 0, 5'h07, 16'h1DAC);
        frame("R7 24-bit slip", {16'h0, payload(2'b10, 5'h07, 16'h0001, 0)}, 24, 1, 1, 0, 1, 0, 0, 0);
        frame("R6 R7 32 bits w/o crc", with_crc(payload(2'b10, 5'h05, 16'h0F0F, 1)), 32, 0, 0, 0, 0, 0, 0, 0);
        crc_en = 1'b1;
    endtask

    task automatic t_width();
        chk(n_wr_hi == n_wr, "R8 strobe width", n_wr_hi, n_wr);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_modes();
        t_crc();
        t_slip();
        t_addr();
        t_length();
        t_nocrc();
        t_width();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule